// File: doc/BRIEF.md
# Packed SIMD Rounding Variable Shifter

This block is a lane-parallel shift datapath for a vector execution unit. It takes two 128-bit operand vectors and returns one 128-bit result. It splits the first operand into lanes of 8, 16, 32 or 64 bits. It shifts each lane by a signed count taken from the low byte of the matching lane of the second operand. A non-negative count shifts the lane left. A negative count performs a right shift that rounds to nearest, by adding half of the last kept bit before the shift.

Control inputs select the lane size, whether first-operand lanes are signed or unsigned, and whether the operation covers the full 128 bits or only the low 64. The decode stage also supplies three register indices. In full-width mode an odd index makes the operation illegal. The block then flags it as undefined and does not produce a result. The result leaves a single register stage one clock after the request.

Top module: `vec_round_shift`

## Requirements
- R1: `size_code` sets the lane width to 8 << `size_code`: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit. Lane i occupies bits [i*W +: W] of each operand and of the result.
- R2: The shift count of a lane is bits [7:0] of the matching lane of `vec_b`, read as a signed 8-bit value for every lane size. The remaining bits of that lane have no effect on the result.
- R3: A count of zero or more shifts the lane left, and the result keeps only the low W bits. A count of W or more gives 0.
- R4: A negative count with magnitude n gives (element + 2^(n-1)) shifted right by n. The element is two's complement with an arithmetic shift when `is_uns`=0, and zero-extended with a logical shift when `is_uns`=1. The addition carries no loss: unsigned 0xFF shifted by -1 gives 0x80.
- R5: A right shift by exactly W gives 0 for signed lanes. For unsigned lanes it gives 1 when the lane's top bit is set and 0 otherwise. A right shift by more than W gives 0 in both modes.
- R6: With `wide`=0 only the low 64 bits are processed, and `out_result[127:64]` is 0. Odd indices are legal in this mode.
- R7: With `wide`=1 and any of `dst_idx`, `src_a_idx` or `src_b_idx` odd, the next cycle shows `out_undef`=1 and `out_valid`=0, and `out_result` is 0.
- R8: A request with `in_valid`=1 appears on the outputs after the next rising edge. With no request, `out_valid` and `out_undef` are 0 in the next cycle and `out_result` keeps its value. `out_valid` and `out_undef` are never both 1.
- R9: The synchronous reset `rst` clears `out_valid`, `out_undef` and `out_result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| size_code | input | 2 | Lane width code (8 << code bits) |
| is_uns | input | 1 | 1: unsigned lanes, 0: signed lanes |
| wide | input | 1 | 1: 128-bit operation, 0: low 64 bits only |
| dst_idx | input | IDX_W | Destination register index (legality check) |
| src_a_idx | input | IDX_W | First source register index (legality check) |
| src_b_idx | input | IDX_W | Second source register index (legality check) |
| vec_a | input | VEC_W | Elements to shift |
| vec_b | input | VEC_W | Per-lane shift counts in each lane's low byte |
| out_valid | output | 1 | Result valid |
| out_undef | output | 1 | Illegal operation flagged |
| out_result | output | VEC_W | Registered shifted vector |

## Verification
Several properties are checked by assertions on every cycle:
- the one-cycle handshake, and that `out_valid` and `out_undef` are never both set;
- the odd-index rule in full-width mode;
- the zeroed upper half in narrow mode;
- that the result is held while idle.

The arithmetic itself is shown only by the bench's scenarios:
- rounding direction for signed and unsigned lanes, and the guard bit on unsigned maxima;
- the edge at exactly W and beyond;
- truncation on left shifts, and that the upper count bits are ignored.

These scenarios compare against hand values and against a wide-precision reference over random operands at all four lane sizes.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

    localparam int VEC_W     = 128;
    localparam int AMT_W     = 8;
    localparam int IDX_W     = 5;
    localparam int NUM_SIZES = 4;
    localparam int MIN_LANE  = 8;

    typedef enum logic [1:0] {
        ESZ_B8  = 2'b00,
        ESZ_B16 = 2'b01,
        ESZ_B32 = 2'b10,
        ESZ_B64 = 2'b11
    } esize_e;

    // Lane width in bits for a size code.
    function automatic int lane_bits(input int code);
        return MIN_LANE << code;
    endfunction

    // Per-cycle decision about the request.
    typedef struct packed {
        logic accept;
        logic illegal;
    } req_flags_t;

endpackage

// File: rtl/vrs_lane.sv
module vrs_lane
    import vrs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] elem,
    input  logic [W-1:0] amt_lane,
    input  logic         is_uns,
    output logic [W-1:0] res
);
    localparam int GW = W + 1;   // one guard bit above the lane

    logic [AMT_W-1:0] amt;
    logic [AMT_W-1:0] mag;
    logic             amt_neg;
    logic [GW-1:0]    ext;
    logic [GW-1:0]    rnd;
    logic [GW-1:0]    sum;
    logic [GW-1:0]    shr;
    logic             unused_guard;

    assign amt     = amt_lane[AMT_W-1:0];
    assign amt_neg = amt[AMT_W-1];
    assign mag     = amt_neg ? (~amt + 1'b1) : amt;

    generate
        if (W > AMT_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^amt_lane[W-1:AMT_W];
        end
    endgenerate

    always_comb begin
        ext = is_uns ? {1'b0, elem} : {elem[W-1], elem};
        rnd = '0;
        sum = '0;
        shr = '0;
        if (!amt_neg) begin
            res = (int'(amt) >= W) ? '0 : (elem << amt);
        end else if (int'(mag) > W) begin
            res = '0;
        end else begin
            rnd = GW'(1) << (mag - 1'b1);
            sum = ext + rnd;
            shr = is_uns ? (sum >> mag) : GW'($signed(sum) >>> mag);
            res = shr[W-1:0];
        end
    end

    assign unused_guard = shr[GW-1];

endmodule

// File: rtl/vrs_lane_array.sv
module vrs_lane_array #(
    parameter int VEC_W = 128,
    parameter int W     = 8
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] amt_vec,
    input  logic             is_uns,
    output logic [VEC_W-1:0] res
);
    localparam int LANES = VEC_W / W;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            vrs_lane #(.W(W)) u_lane (
                .elem     (src[i*W +: W]),
                .amt_lane (amt_vec[i*W +: W]),
                .is_uns   (is_uns),
                .res      (res[i*W +: W])
            );
        end
    endgenerate

endmodule

// File: rtl/vrs_legal.sv
module vrs_legal #(
    parameter int IDX_W = 5
) (
    input  logic             wide,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    output logic             illegal
);
    logic unused_idx_hi;

    // Full-width operations need even (pair-aligned) register indices.
    assign illegal = wide & (dst_idx[0] | src_a_idx[0] | src_b_idx[0]);
    assign unused_idx_hi = ^{dst_idx[IDX_W-1:1], src_a_idx[IDX_W-1:1], src_b_idx[IDX_W-1:1]};

endmodule

// File: rtl/vec_round_shift.sv
module vec_round_shift
    import vrs_pkg::*;
#(
    parameter int VEC_W = vrs_pkg::VEC_W,
    parameter int IDX_W = vrs_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       size_code,
    input  logic             is_uns,
    input  logic             wide,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic             out_valid,
    output logic             out_undef,
    output logic [VEC_W-1:0] out_result
);
    localparam int HALF_W = VEC_W / 2;

    logic [VEC_W-1:0] by_size [NUM_SIZES];
    logic [VEC_W-1:0] sel_res;
    logic             illegal;
    esize_e           esz;
    req_flags_t       flags;

    // One lane array per element size; the size code picks one.
    generate
        for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
            vrs_lane_array #(.VEC_W(VEC_W), .W(lane_bits(k))) u_arr (
                .src     (vec_a),
                .amt_vec (vec_b),
                .is_uns  (is_uns),
                .res     (by_size[k])
            );
        end
    endgenerate

    vrs_legal #(.IDX_W(IDX_W)) u_legal (
        .wide      (wide),
        .dst_idx   (dst_idx),
        .src_a_idx (src_a_idx),
        .src_b_idx (src_b_idx),
        .illegal   (illegal)
    );

    assign esz = esize_e'(size_code);

    always_comb begin
        unique case (esz)
            ESZ_B8:  sel_res = by_size[0];
            ESZ_B16: sel_res = by_size[1];
            ESZ_B32: sel_res = by_size[2];
            default: sel_res = by_size[3];
        endcase
        if (!wide) sel_res[VEC_W-1:HALF_W] = '0;
    end

    assign flags.accept  = in_valid & ~illegal;
    assign flags.illegal = in_valid & illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_undef  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= flags.accept;
            out_undef <= flags.illegal;
            if (in_valid) out_result <= illegal ? '0 : sel_res;
        end
    end

    // R6: narrow requests leave the upper half zero
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide) |=> (out_result[VEC_W-1:HALF_W] == '0) && out_valid);

    // R7: odd index in full-width mode raises undefined, no valid
    p_odd_idx_undef_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide && (dst_idx[0] || src_a_idx[0] || src_b_idx[0]))
        |=> (out_undef && !out_valid && out_result == '0));

    // R8: valid and undefined never together
    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_undef));

    // R8: idle cycle gives no flags and holds the result
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_undef && $stable(out_result)));

    // R8: every request produces exactly one outcome next cycle
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> $countones({out_valid, out_undef}) == 1);

endmodule

// File: tb/vec_round_shift_tb.sv
`timescale 1ns/1ps
module vec_round_shift_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   size_code = 2'b00;
    logic         is_uns = 1'b0;
    logic         wide = 1'b1;
    logic [4:0]   dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
    logic [127:0] vec_a = '0, vec_b = '0;
    logic         out_valid, out_undef;
    logic [127:0] out_result;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    vec_round_shift u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
        .is_uns(is_uns), .wide(wide), .dst_idx(dst_idx), .src_a_idx(src_a_idx),
        .src_b_idx(src_b_idx), .vec_a(vec_a), .vec_b(vec_b),
        .out_valid(out_valid), .out_undef(out_undef), .out_result(out_result)
    );

    // Replicate the low w bits of v across 128 bits.
    function automatic logic [127:0] fill(input logic [63:0] v, input int w);
        logic [127:0] r;
        logic [63:0]  m;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r = '0;
        for (int i = 0; i < 128 / w; i++) r = r | (128'(v & m) << (i * w));
        return r;
    endfunction

    // Wide-precision reference of the lane arithmetic.
    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] sz, input logic uns, input logic wd);
        int w, nl;
        logic [127:0] r;
        logic [63:0]  m;
        w  = 8 << sz;
        nl = (wd ? 128 : 64) / w;
        m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r  = '0;
        for (int i = 0; i < nl; i++) begin
            logic [63:0]         el;
            logic signed [199:0] e;
            int                  s;
            el = 64'(a >> (i * w)) & m;
            s  = int'($signed(8'(b >> (i * w))));
            e  = $signed({136'd0, el});
            if (!uns && el[w-1]) e = e - (200'sd1 <<< w);
            if (s >= 0) e = e <<< s;
            else        e = (e + (200'sd1 <<< (-s - 1))) >>> (-s);
            r = r | (128'(64'(e) & m) << (i * w));
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                          input logic uns, input logic wd,
                          input logic [4:0] d, input logic [4:0] ma, input logic [4:0] nb);
        @(negedge clk);
        in_valid = 1'b1; vec_a = a; vec_b = b; size_code = sz; is_uns = uns; wide = wd;
        dst_idx = d; src_a_idx = ma; src_b_idx = nb;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Legal operation: compare against hand value and reference.
    task automatic expect_op(input string tag, input logic [127:0] a, input logic [127:0] b,
                             input logic [1:0] sz, input logic uns, input logic [127:0] exp);
        run_op(a, b, sz, uns, 1'b1, 5'd0, 5'd2, 5'd4);
        chk({tag, " valid"}, 128'(out_valid), 128'(1));
        chk({tag, " hand"}, out_result, exp);
        chk({tag, " ref"}, out_result, model(a, b, sz, uns, 1'b1));
    endtask

    task automatic t_reset;
        chk("R9 reset valid", 128'(out_valid), 128'(0));
        chk("R9 reset undef", 128'(out_undef), 128'(0));
        chk("R9 reset result", out_result, '0);
    endtask

    task automatic t_sizes;
        expect_op("R1 8b",  fill(64'h01, 8),   fill(64'h03, 8),   2'd0, 1'b0, fill(64'h08, 8));
        expect_op("R1 16b", fill(64'h0101, 16), fill(64'h04, 16), 2'd1, 1'b0, fill(64'h1010, 16));
        expect_op("R1 32b", fill(64'h1, 32),   fill(64'd31, 32),  2'd2, 1'b0, fill(64'h80000000, 32));
        expect_op("R1 64b", fill(64'h1, 64),   fill(64'd63, 64),  2'd3, 1'b1, fill(64'h8000000000000000, 64));
    endtask

    task automatic t_amount_byte;
        expect_op("R2 upper ignored pos", fill(64'h0003, 16), fill(64'h7F01, 16), 2'd1, 1'b0, fill(64'h0006, 16));
        expect_op("R2 upper ignored neg", fill(64'h0003, 16), fill(64'h80FF, 16), 2'd1, 1'b0, fill(64'h0002, 16));
        expect_op("R2 64b byte only", fill(64'h10, 64), fill(64'hFFFF_FFFF_FFFF_FF02, 64), 2'd3, 1'b0, fill(64'h40, 64));
    endtask

    task automatic t_left;
        expect_op("R3 truncate", fill(64'h81, 8), fill(64'h01, 8), 2'd0, 1'b1, fill(64'h02, 8));
        expect_op("R3 shift W",  fill(64'hFF, 8), fill(64'h08, 8), 2'd0, 1'b1, '0);
        expect_op("R3 shift 7",  fill(64'h01, 8), fill(64'h07, 8), 2'd0, 1'b0, fill(64'h80, 8));
        expect_op("R3 shift 127 on 64b", fill(64'h1, 64), fill(64'h7F, 64), 2'd3, 1'b0, '0);
    endtask

    task automatic t_rounding;
        expect_op("R4 signed -3>>1", fill(64'hFD, 8), fill(64'hFF, 8), 2'd0, 1'b0, fill(64'hFF, 8));
        expect_op("R4 signed -5>>1", fill(64'hFB, 8), fill(64'hFF, 8), 2'd0, 1'b0, fill(64'hFE, 8));
        expect_op("R4 signed 5>>1",  fill(64'h05, 8), fill(64'hFF, 8), 2'd0, 1'b0, fill(64'h03, 8));
        expect_op("R4 unsigned max guard", fill(64'hFF, 8), fill(64'hFF, 8), 2'd0, 1'b1, fill(64'h80, 8));
        expect_op("R4 u64 max guard", fill(64'hFFFF_FFFF_FFFF_FFFF, 64), fill(64'hFF, 64), 2'd3, 1'b1,
                  fill(64'h8000_0000_0000_0000, 64));
        expect_op("R4 s32 -7>>2", fill(64'hFFFF_FFF9, 32), fill(64'hFE, 32), 2'd2, 1'b0, fill(64'hFFFF_FFFE, 32));
    endtask

    task automatic t_edges;
        expect_op("R5 u top set >>W",  fill(64'h80, 8), fill(64'hF8, 8), 2'd0, 1'b1, fill(64'h01, 8));
        expect_op("R5 u top clr >>W",  fill(64'h7F, 8), fill(64'hF8, 8), 2'd0, 1'b1, '0);
        expect_op("R5 s min >>W",      fill(64'h80, 8), fill(64'hF8, 8), 2'd0, 1'b0, '0);
        expect_op("R5 s max >>W",      fill(64'h7F, 8), fill(64'hF8, 8), 2'd0, 1'b0, '0);
        expect_op("R5 u >>W+1",        fill(64'hFF, 8), fill(64'hF7, 8), 2'd0, 1'b1, '0);
        expect_op("R5 u64 >>64",       fill(64'h8000_0000_0000_0000, 64), fill(64'hC0, 64), 2'd3, 1'b1, fill(64'h1, 64));
        expect_op("R5 s64 >>128",      fill(64'h8000_0000_0000_0000, 64), fill(64'h80, 64), 2'd3, 1'b0, '0);
    endtask

    task automatic t_narrow;
        logic [127:0] a, b;
        a = {$urandom, $urandom, $urandom, $urandom};
        b = fill(64'h02, 8);
        run_op(a, b, 2'd0, 1'b1, 1'b0, 5'd1, 5'd3, 5'd5);
        chk("R6 narrow odd idx valid", 128'(out_valid), 128'(1));
        chk("R6 narrow upper zero", out_result[127:64], '0);
        chk("R6 narrow ref", out_result, model(a, b, 2'd0, 1'b1, 1'b0));
    endtask

    task automatic t_illegal;
        run_op(fill(64'h11, 8), fill(64'h01, 8), 2'd0, 1'b0, 1'b1, 5'd3, 5'd0, 5'd0);
        chk("R7 odd dst undef", 128'(out_undef), 128'(1));
        chk("R7 odd dst no valid", 128'(out_valid), 128'(0));
        chk("R7 odd dst result", out_result, '0);
        run_op(fill(64'h11, 8), fill(64'h01, 8), 2'd0, 1'b0, 1'b1, 5'd0, 5'd7, 5'd0);
        chk("R7 odd srcA undef", 128'(out_undef), 128'(1));
        run_op(fill(64'h11, 8), fill(64'h01, 8), 2'd0, 1'b0, 1'b1, 5'd0, 5'd0, 5'd9);
        chk("R7 odd srcB undef", 128'(out_undef), 128'(1));
        chk("R7 odd srcB no valid", 128'(out_valid), 128'(0));
    endtask

    task automatic t_timing;
        logic [127:0] held;
        expect_op("R8 op", fill(64'h03, 8), fill(64'h01, 8), 2'd0, 1'b0, fill(64'h06, 8));
        held = out_result;
        @(negedge clk);
        chk("R8 idle valid", 128'(out_valid), 128'(0));
        chk("R8 idle undef", 128'(out_undef), 128'(0));
        chk("R8 idle hold", out_result, held);
    endtask

    task automatic t_random;
        for (int t = 0; t < 160; t++) begin
            logic [127:0] a, b;
            logic [1:0]   sz;
            logic         uns, wd;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            sz = 2'($urandom); uns = 1'($urandom); wd = 1'($urandom);
            run_op(a, b, sz, uns, wd, 5'd2, 5'd4, 5'd6);
            chk("R4 random vs ref", out_result, model(a, b, sz, uns, wd));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_sizes();
        t_amount_byte();
        t_left();
        t_rounding();
        t_edges();
        t_narrow();
        t_illegal();
        t_timing();
        t_random();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule